// File: doc/BRIEF.md
# Opcode-Triggered Address Bus Walker

This block sits at the fetch end of a small processor. It watches each 8-bit opcode that the fetch path delivers. In normal operation it forwards the program counter onto the address bus and mirrors the fetch request onto the read strobe.

Two reserved opcode values put the block into a built-in self-test sweep. From the cycle after such an opcode, the address bus becomes a free-running incrementing counter. The read strobe stays high on every cycle, so each address line toggles at its natural binary rate and can be checked at board level.

The sweep does not stop by itself. It skips no cycles for fetches, and it ignores later opcodes and interrupt requests. The only way out is a synchronous reset.

Top module: `addr_walker_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block leaves that edge in normal mode: `walk_active` is 0, `bus_addr` equals `pc_in` and `bus_rd` equals `fetch_req`.
- R2: In normal mode, `bus_addr` follows `pc_in` and `bus_rd` follows `fetch_req` combinationally, in the same cycle.
- R3: In normal mode, a clock edge with `op_valid` high and `op_code` equal to 8'h9D or 8'hDD puts the block into walk mode, and `walk_active` is 1 from that edge on.
- R4: Any other opcode value, or either reserved value presented with `op_valid` low, leaves the block in normal mode.
- R5: In the first walk cycle, `bus_addr` equals the `pc_in` value present at the triggering edge plus one. The triggering opcode is taken to have been fetched from that `pc_in` address.
- R6: In walk mode, `bus_rd` is 1 on every cycle and `bus_addr` rises by exactly one per cycle. No fetch address is inserted, and `pc_in` and `fetch_req` have no effect on the outputs.
- R7: The walk address is 16 bits wide and goes from 16'hFFFF to 16'h0000 on the next cycle without stopping.
- R8: In walk mode, `irq` has no effect on `walk_active`, `bus_addr` or `bus_rd`.
- R9: In walk mode, further opcodes have no effect, the two reserved values included; they do not restart the sweep.
- R10: Walk mode is left only through reset. `walk_active` drops to 0 at the first reset edge, and the outputs show normal-mode passthrough from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | `op_code` holds a fetched opcode this cycle |
| op_code | input | 8 | Fetched opcode |
| irq | input | 1 | Interrupt request; no effect on the sweep |
| pc_in | input | 16 | Program counter; the opcode's fetch address |
| fetch_req | input | 1 | Fetch read request from the core |
| bus_addr | output | 16 | Address bus |
| bus_rd | output | 1 | Read strobe |
| walk_active | output | 1 | High while the self-test sweep runs |

## Verification
Two functions can act in the same cycle, and the bench provokes each pair deliberately.

- **Reserved opcode during the sweep.** A reserved opcode arrives while the sweep runs. The sweep must not reload from `pc_in` and must keep counting.
- **Interrupt with a trigger.** An interrupt request is raised on the very edge that carries a trigger. The trigger must still take effect.
- **Reset during the sweep.** Reset lands in the middle of a sweep. Leaving the sweep must win over the increment at that edge.

A behavioural reference model in the bench judges every cycle. It tracks the mode and address with plain integers and compares all three outputs each cycle.

// File: rtl/walk_pkg.sv
package walk_pkg;

  localparam int          OP_W       = 8;
  localparam logic [7:0]  TEST_OP_LO = 8'h9D;
  localparam logic [7:0]  TEST_OP_HI = 8'hDD;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_WALK = 1'b1
  } mode_e;

  // True for either reserved self-test opcode.
  function automatic logic is_test_op(input logic [OP_W-1:0] op);
    return (op == TEST_OP_LO) || (op == TEST_OP_HI);
  endfunction

endpackage

// File: rtl/walk_mode_fsm.sv
module walk_mode_fsm
  import walk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  output logic            trig_hit,
  output logic            walk_on
);

  mode_e mode_q, mode_d;

  // A trigger counts only in run mode; in walk mode opcodes are dead.
  assign trig_hit = op_valid && is_test_op(op_code) && (mode_q == MODE_RUN);

  always_comb begin
    mode_d = mode_q;
    if (trig_hit) mode_d = MODE_WALK;
  end

  // No path back to MODE_RUN except reset.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RUN;
    else     mode_q <= mode_d;
  end

  assign walk_on = (mode_q == MODE_WALK);

endmodule

// File: rtl/walk_addr_ctr.sv
module walk_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] seed,
  output logic [ADDR_W-1:0] addr_q
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // Modulo-2^ADDR_W increment, so the sweep wraps naturally.
  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= bump(seed);
    else if (step) addr_q <= bump(addr_q);
  end

endmodule

// File: rtl/bus_select.sv
module bus_select #(
  parameter int ADDR_W = 16
) (
  input  logic              walk_on,
  input  logic [ADDR_W-1:0] walk_addr,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              fetch_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd
);

  always_comb begin
    if (walk_on) begin
      bus_addr = walk_addr;
      bus_rd   = 1'b1;
    end else begin
      bus_addr = pc_in;
      bus_rd   = fetch_req;
    end
  end

endmodule

// File: rtl/addr_walker_top.sv
module addr_walker_top
  import walk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic              irq,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              fetch_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              walk_active
);

  // Named internal events for the checker.
  logic              trig_hit;
  logic              walk_on;
  logic [ADDR_W-1:0] walk_addr;

  walk_mode_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .trig_hit (trig_hit),
    .walk_on  (walk_on)
  );

  walk_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load   (trig_hit),
    .step   (walk_on),
    .seed   (pc_in),
    .addr_q (walk_addr)
  );

  bus_select #(.ADDR_W(ADDR_W)) u_sel (
    .walk_on   (walk_on),
    .walk_addr (walk_addr),
    .pc_in     (pc_in),
    .fetch_req (fetch_req),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd)
  );

  assign walk_active = walk_on;

endmodule

// File: rtl/walk_checker.sv
module walk_checker
  import walk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [OP_W-1:0]   op_code,
  input logic              irq,
  input logic [ADDR_W-1:0] pc_in,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              walk_active,
  input logic              trig_hit
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  a_r3_enter_walk: assert property (@(posedge clk) disable iff (rst)
    (!walk_active && op_valid && is_test_op(op_code)) |=> walk_active);

  a_r4_no_entry: assert property (@(posedge clk) disable iff (rst)
    (!walk_active && !trig_hit) |=> !walk_active);

  a_r5_first_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_active) |-> (bus_addr == $past(pc_in) + ONE));

  a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
    (walk_active && $past(walk_active)) |-> (bus_addr == $past(bus_addr) + ONE));

  a_r6_strobe_on: assert property (@(posedge clk) disable iff (rst)
    walk_active |-> bus_rd);

  a_r8_irq_ignored: assert property (@(posedge clk) disable iff (rst)
    (walk_active && irq) |=> walk_active);

  a_r9_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    walk_active |-> !trig_hit);

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    walk_active |=> walk_active);

endmodule

bind addr_walker_top walk_checker #(.ADDR_W(ADDR_W)) u_walk_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .irq         (irq),
  .pc_in       (pc_in),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .walk_active (walk_active),
  .trig_hit    (trig_hit)
);

// File: tb/tb_addr_walker_top.sv
module tb_addr_walker_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [7:0]  op_code;
  logic        irq;
  logic [15:0] pc_in;
  logic        fetch_req;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic        walk_active;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  int    m_act  = 0;
  int    m_addr = 0;
  int    seed   = 32'h1ace;
  string req    = "R1";
  bit    done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_walker_top dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .irq(irq),
    .pc_in(pc_in), .fetch_req(fetch_req), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .walk_active(walk_active)
  );

  function automatic int rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // One cycle: drive at negedge, compare at negedge+1, then let the model
  // take the rising edge with the same inputs.
  task automatic cyc(input bit r, input bit v, input int op, input int pc,
                     input bit fr, input bit iq);
    int exp_a, exp_r;
    rst = r; op_valid = v; op_code = op[7:0]; pc_in = pc[15:0];
    fetch_req = fr; irq = iq;
    #1;
    exp_a = (m_act != 0) ? m_addr : (pc & 16'hFFFF);
    exp_r = (m_act != 0) ? 1 : int'(fr);
    n_cmp++;
    if (int'(bus_addr) != exp_a || int'(bus_rd) != exp_r || int'(walk_active) != m_act) begin
      n_bad++;
      $display("FAIL %s: addr/rd/act actual %h/%0d/%0d expected %h/%0d/%0d",
               req, bus_addr, bus_rd, walk_active, exp_a[15:0], exp_r, m_act);
    end
    @(posedge clk);
    if (r) m_act = 0;
    else if (m_act == 0 && v && (op == 8'h9D || op == 8'hDD)) begin
      m_act = 1; m_addr = (pc + 1) & 16'hFFFF;
    end else if (m_act != 0) m_addr = (m_addr + 1) & 16'hFFFF;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    req = "R1";
    cyc(1, 0, 0, 16'h0100, 0, 0);
    cyc(1, 1, 8'h9D, 16'h0200, 1, 1);
    cyc(0, 0, 0, 16'h0300, 1, 0);

    // R2/R4: normal traffic with near-miss opcodes
    req = "R4";
    cyc(0, 1, 8'h9C, 16'h1000, 1, 0);
    cyc(0, 1, 8'h9E, 16'h1001, 0, 0);
    cyc(0, 1, 8'h5D, 16'h1002, 1, 1);
    cyc(0, 1, 8'hDC, 16'h1003, 1, 0);
    cyc(0, 0, 8'h9D, 16'h1004, 1, 0);
    cyc(0, 0, 8'hDD, 16'h1005, 0, 1);
    req = "R2";
    for (int i = 0; i < 200; i++) begin
      int op = rnd() & 8'hFF;
      if (op == 8'h9D || op == 8'hDD) op = 8'h00;
      cyc(0, rnd() & 1, op, rnd(), rnd() & 1, rnd() & 1);
    end

    // R3/R5: trigger 9D from 1234, irq high on the same edge
    req = "R3";
    cyc(0, 1, 8'h9D, 16'h1234, 1, 1);
    req = "R5";
    cyc(0, 0, 0, 16'h4444, 0, 0);
    // R6/R8/R9: sweep with junk inputs, irq and reserved opcodes
    req = "R6";
    for (int i = 0; i < 100; i++) cyc(0, rnd() & 1, rnd(), rnd(), 0, 0);
    req = "R8";
    for (int i = 0; i < 50; i++) cyc(0, 0, 0, rnd(), rnd() & 1, 1);
    req = "R9";
    for (int i = 0; i < 20; i++) cyc(0, 1, (i & 1) ? 8'h9D : 8'hDD, 16'h0010, 1, i & 1);

    // R10: reset in mid-sweep
    req = "R10";
    cyc(1, 1, 8'hDD, 16'h7777, 0, 1);
    cyc(0, 0, 0, 16'h2222, 0, 0);
    cyc(0, 0, 0, 16'h2223, 1, 0);

    // R7: wrap, trigger DD from FFFD
    req = "R7";
    cyc(0, 1, 8'hDD, 16'hFFFD, 1, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 16'hABCD, 0, 0);

    // R6: long sweep across a wider span
    req = "R6";
    for (int i = 0; i < 3000; i++) cyc(0, 0, 0, rnd(), rnd() & 1, rnd() & 1);

    req = "R10";
    cyc(1, 0, 0, 16'h5555, 1, 0);
    cyc(0, 0, 0, 16'h5556, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule